// File: doc/BRIEF.md
# I2C Target Byte Engine with Software-Released Clock Stretching

This block is an I2C target that moves one byte at a time and stretches the clock after each byte until software services it. It watches the bus for START and STOP, takes a single fixed 7-bit address, acknowledges it on its own, and then either shifts received bits in or shifts a byte out on SDA. After each byte it holds SCL low. A control bit chooses whether that hold begins after the eighth clock or after the ninth (acknowledge) clock. Each time a hold begins, a one-cycle interrupt pulse goes out.

The stretch ends only through register writes, and it does so as a side effect of the access. A receiver is freed in two ways: by setting the release bit, or by writing 0xFF to the data register. The all-ones value keeps SDA released while the next byte arrives. A transmitter is freed by writing its next byte. The start-request and stop-request bits also end a pending hold. When receiving, the acknowledge level comes from the acknowledge-enable bit as it stands just before the acknowledge clock.

Both bus lines are open-drain. The block only drives active-low enables. It samples each pin through a two-flop synchronizer, followed by a glitch filter that is FILT system clocks long.

Top module: `i2c_wait_target`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, and reads of the control register (bus_addr 0) and the status register (bus_addr 2) return 0x00.
- R2: When the byte after START carries address OWN_ADDR in bits 7:1, the block drives ACK (SDA low) on the ninth clock, copies bit 0 (1 = read) into status bit 1, sets status bit 4 (addressed), and holds SCL low after that ninth clock. Any other address gets no ACK and no hold.
- R3: Control bit 1 selects where a data byte's hold begins. When the bit is 0, SCL is held after the eighth clock. When the bit is 1, SCL is held after the ninth clock, and the eighth clock is not stretched. Status bit 0 reads 1 while SCL is held.
- R4: Writing control bit 2 (release) as 1 ends a receive hold. The bit always reads back as 0. A control write with bits 4:2 all 0 leaves the hold in place.
- R5: While receiving, the data register (bus_addr 1) returns the byte just received, MSB first. Writing 0xFF to it ends a receive hold.
- R6: While transmitting, writing a byte to the data register ends the hold, and that byte goes out MSB first, one bit per clock.
- R7: On the acknowledge clock of a received data byte, SDA is driven low when control bit 0 (acknowledge enable) is 1 and released when it is 0. The value used is the one written before the hold is released.
- R8: Writing control bit 3 (start request) or control bit 4 (stop request) as 1 ends a pending hold.
- R9: START sets status bit 2 and clears bit 3. STOP sets bit 3 and clears bits 2, 4, 1 and 0. Either condition clears any hold and restarts bit counting, so a repeated START in the middle of a byte leaves a clean address byte that follows it.
- R10: irq pulses high for exactly one cycle each time a hold begins.
- R11: A NACK from the master after a transmitted byte ends the transfer. No hold follows, and SDA stays released.
- R12: A low pulse on SDA shorter than FILT system clocks, while SCL is high, is not taken as a bus condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretch) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| irq | output | 1 | One-cycle pulse when a hold begins |

## Verification
The bench uses the default parameters: OWN_ADDR = 7'h2A and FILT = 3. The half bit time is 20 system clocks, which is well above the synchronizer and filter delay. Every stretch is therefore set long before the master tries to raise SCL, and both the held and the unheld clocks can be observed directly on the wired-AND bus. With FILT at 3, a one-cycle SDA pulse falls clearly inside the rejection window. The transfers cover several byte values, a mid-byte repeated START and a wrong address.

// File: rtl/i2c_wait_target.sv
`timescale 1ns/1ps
module i2c_wait_target #(
  parameter logic [6:0] OWN_ADDR = 7'h2A,
  parameter int         FILT     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int FW = $clog2(FILT + 1);

  logic [1:0]    s1, s2, flt, flt_q;
  logic [FW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; flt_q <= 2'b11;
      fcnt[0] <= '0; fcnt[1] <= '0;
    end else begin
      s1 <= {sda_i, scl_i};
      s2 <= s1;
      flt_q <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = flt[0] & ~flt_q[0];
  assign scl_fall = ~flt[0] & flt_q[0];
  assign start_c  = flt[0] & flt_q[0] & ~flt[1] & flt_q[1];
  assign stop_c   = flt[0] & flt_q[0] & flt[1] & ~flt_q[1];

  logic       active, addr_ph, addressed, tx, skip, nack, ack_q, wait_q;
  logic       rel_q, ack_en, w9, st_seen, sp_seen;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       wr_ctrl, wr_data, sw_rel, tx_data;

  assign wr_ctrl = bus_we & (bus_addr == 2'd0);
  assign wr_data = bus_we & (bus_addr == 2'd1);
  assign tx_data = addressed & tx & ~addr_ph;
  assign sw_rel  = rel_q | (wr_ctrl & |bus_wdata[4:3]) |
                   (wr_data & (tx | (bus_wdata == 8'hFF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; addr_ph <= 1'b0; addressed <= 1'b0; tx <= 1'b0;
      skip <= 1'b0; nack <= 1'b0; ack_q <= 1'b0; wait_q <= 1'b0;
      rel_q <= 1'b0; ack_en <= 1'b0; w9 <= 1'b0; st_seen <= 1'b0;
      sp_seen <= 1'b0; cnt <= '0; sh <= '0; irq <= 1'b0;
    end else begin
      irq   <= 1'b0;
      rel_q <= wr_ctrl & bus_wdata[2];
      if (wr_ctrl) begin
        ack_en <= bus_wdata[0];
        w9     <= bus_wdata[1];
      end
      if (start_c) begin
        active <= 1'b1; addr_ph <= 1'b1; addressed <= 1'b0; tx <= 1'b0;
        skip <= 1'b1; nack <= 1'b0; wait_q <= 1'b0; cnt <= '0;
        st_seen <= 1'b1; sp_seen <= 1'b0;
      end else if (stop_c) begin
        active <= 1'b0; addr_ph <= 1'b0; addressed <= 1'b0; tx <= 1'b0;
        wait_q <= 1'b0; cnt <= '0; st_seen <= 1'b0; sp_seen <= 1'b1;
      end else begin
        if (wait_q && sw_rel) wait_q <= 1'b0;
        if (wr_data) sh <= bus_wdata;
        if (wait_q && cnt == 4'd8 && !addr_ph && !tx) ack_q <= ack_en;
        if (active && scl_rise) begin
          if (cnt < 4'd8 && !tx_data) sh <= {sh[6:0], flt[1]};
          if (cnt == 4'd8 && tx_data) nack <= flt[1];
        end
        if (active && scl_fall) begin
          if (skip) skip <= 1'b0;
          else if (cnt == 4'd7) begin
            cnt <= 4'd8;
            if (addr_ph) begin
              ack_q <= (sh[7:1] == OWN_ADDR);
              if (sh[7:1] == OWN_ADDR) begin
                addressed <= 1'b1;
                tx        <= sh[0];
              end
            end else begin
              ack_q <= ack_en;
              if (!w9) begin wait_q <= 1'b1; irq <= 1'b1; end
            end
          end else if (cnt == 4'd8) begin
            cnt <= '0;
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (addressed) begin wait_q <= 1'b1; irq <= 1'b1; end
              else active <= 1'b0;
            end else if (tx && nack) active <= 1'b0;
            else if (w9) begin wait_q <= 1'b1; irq <= 1'b1; end
          end else begin
            cnt <= cnt + 4'd1;
            if (tx_data) sh <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign scl_oe = wait_q;
  assign sda_oe = active & (
      ((cnt == 4'd8) & ack_q & (addr_ph | (addressed & ~tx))) |
      (tx_data & (cnt < 4'd8) & ~sh[7]));

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {6'b0, w9, ack_en};
      2'd1:    bus_rdata = sh;
      2'd2:    bus_rdata = {3'b0, addressed, sp_seen, st_seen, tx, wait_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_hold_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> irq);
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_rel_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> !rel_q);
  assert_rel_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && wait_q && !start_c && !stop_c && !scl_fall) |=> !wait_q);
  assert_tx_write_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && wait_q && tx && !start_c && !stop_c && !scl_fall) |=> !wait_q);
  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (!wait_q && cnt == 4'd0));
  assert_nack_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 4'd8 && !addr_ph && !tx && !ack_q) |-> !sda_oe);
endmodule

// File: tb/i2c_wait_target_tb.sv
`timescale 1ns/1ps
module i2c_wait_target_tb;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int H = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq, scl_bus, sda_bus;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd2;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_wait_target #(.OWN_ADDR(ADDR), .FILT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  int checks = 0, errors = 0, irq_cnt = 0;
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pre(input logic b);
    m_sda = b; wait_n(H); m_scl = 1'b1;
  endtask

  task automatic post(output logic r);
    while (!scl_bus) @(negedge clk);
    wait_n(H); r = sda_bus; m_scl = 1'b0; wait_n(4);
  endtask

  task automatic byte_w(input logic [7:0] d, input bit pre_done);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      if (!(i == 7 && pre_done)) pre(d[i]);
      post(r);
    end
  endtask

  task automatic byte_r(output logic [7:0] d, input bit pre_done);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      if (!(i == 7 && pre_done)) pre(1'b1);
      post(r); d[i] = r;
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_n(H); m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_n(H); m_sda = 1'b0; wait_n(H); m_scl = 1'b0; wait_n(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(H); m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    wait_n(H); m_sda = 1'b1; wait_n(H);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", "scl_oe", scl_oe, 0);
    check("R1", "sda_oe", sda_oe, 0);
    check("R1", "irq count", irq_cnt, 0);
    rd(2'd0, d); check("R1", "control", d, 8'h00);
    rd(2'd2, d); check("R1", "status", d, 8'h00);
  endtask

  task automatic t_receive();
    logic r; logic [7:0] d; int base;
    base = irq_cnt;
    wr(2'd0, 8'h01);
    bus_start();
    byte_w({ADDR, 1'b0}, 0);
    pre(1'b1); post(r); check("R2", "address ack", r, 0);
    pre(1'b1); wait_n(10);
    check("R2", "held after address", scl_bus, 0);
    check("R10", "irq after address", irq_cnt, base + 1);
    rd(2'd2, d); check("R2", "status in write hold", d, 8'h15);
    wr(2'd0, 8'h05); wait_n(5);
    rd(2'd0, d); check("R4", "release bit reads 0", d, 8'h01);
    byte_w(8'hA5, 1);
    pre(1'b1); wait_n(10);
    check("R3", "held after 8th clock", scl_bus, 0);
    rd(2'd1, d); check("R5", "received A5", d, 8'hA5);
    check("R10", "irq after byte", irq_cnt, base + 2);
    wr(2'd1, 8'hFF);
    post(r); check("R7", "ack with enable set", r, 0);
    byte_w(8'h3C, 0);
    pre(1'b1); wait_n(10);
    check("R3", "held after 8th clock", scl_bus, 0);
    wr(2'd0, 8'h00); wait_n(10);
    check("R4", "plain control write keeps hold", scl_bus, 0);
    wr(2'd0, 8'h04);
    post(r); check("R7", "nack with enable cleared", r, 1);
    wr(2'd0, 8'h03);
    byte_w(8'h5A, 0);
    pre(1'b1); wait_n(10);
    check("R3", "8th clock free in 9-clock mode", scl_bus, 1);
    post(r); check("R7", "ack in 9-clock mode", r, 0);
    pre(1'b0); wait_n(10);
    check("R3", "held after 9th clock", scl_bus, 0);
    rd(2'd2, d); check("R3", "status wait bit", d[0], 1);
    rd(2'd1, d); check("R5", "received 5A", d, 8'h5A);
    wr(2'd0, 8'h0B); wait_n(10);
    check("R8", "start request frees", scl_bus, 1);
    byte_w(8'h11, 1);
    pre(1'b1); post(r);
    pre(1'b1); wait_n(10);
    check("R10", "irq count", irq_cnt, base + 5);
    wr(2'd0, 8'h13); wait_n(10);
    check("R8", "stop request frees", scl_bus, 1);
    post(r);
    bus_stop();
    rd(2'd2, d); check("R9", "status after stop", d, 8'h08);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    @(negedge clk); m_sda = 1'b0; @(negedge clk); m_sda = 1'b1;
    wait_n(12);
    rd(2'd2, d); check("R12", "short SDA pulse ignored", d, 8'h08);
  endtask

  task automatic t_transmit();
    logic r; logic [7:0] d; int base;
    base = irq_cnt;
    wr(2'd0, 8'h03);
    bus_start();
    pre(1'b1); post(r); pre(1'b0); post(r); pre(1'b1); post(r);
    bus_start();
    rd(2'd2, d); check("R9", "status after repeated start", d, 8'h04);
    byte_w({ADDR, 1'b1}, 0);
    pre(1'b1); post(r); check("R9", "address ack after restart", r, 0);
    pre(1'b1); wait_n(10);
    check("R2", "held after read address", scl_bus, 0);
    rd(2'd2, d); check("R2", "status in read hold", d, 8'h17);
    wr(2'd1, 8'hC6);
    byte_r(d, 1); check("R6", "byte C6 out", d, 8'hC6);
    pre(1'b0); post(r);
    pre(1'b1); wait_n(10);
    check("R6", "held after acked byte", scl_bus, 0);
    check("R10", "irq in read", irq_cnt, base + 2);
    wr(2'd1, 8'h5B);
    byte_r(d, 1); check("R6", "byte 5B out", d, 8'h5B);
    pre(1'b1); post(r);
    pre(1'b1); wait_n(10);
    check("R11", "no hold after nack", scl_bus, 1);
    check("R11", "sda released after nack", sda_oe, 0);
    check("R11", "no irq after nack", irq_cnt, base + 2);
    post(r);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic r; logic [7:0] d; int base;
    base = irq_cnt;
    bus_start();
    byte_w({ADDR ^ 7'h01, 1'b0}, 0);
    pre(1'b1); post(r); check("R2", "no ack for other address", r, 1);
    pre(1'b1); wait_n(10);
    check("R2", "no hold for other address", scl_bus, 1);
    check("R2", "no irq for other address", irq_cnt, base);
    rd(2'd2, d); check("R2", "status not addressed", d, 8'h04);
    post(r);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(5);
    t_reset();
    t_receive();
    t_glitch();
    t_transmit();
    t_wrong_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule